// File: doc/BRIEF.md
# Branch Resolve and Fetch-Hold Controller

This block is the control core of a five-stage in-order pipeline (IF, ID, RF, EX, WB). It owns the program counter with its own incrementer, the instruction word held by each stage from ID onward, and the negative/zero flag register. With it in place, programs need no branch delay slots. When a branch reaches ID, a three-state machine freezes the program counter. It drops the word that was fetched behind the branch and sends nop words down the pipe until the branch reaches EX. By then every older instruction has left EX, so the flags hold the result of the last real ALU operation.

In EX the branch condition is checked against the stored flags. If the branch is taken, the target supplied by the EX datapath is loaded into the program counter at the end of that cycle. If it is not taken, the counter already points at the word after the branch. In the following cycle fetching resumes from that address. The ALU, the register file and the memories are outside this block. The instruction memory read port is a combinational lookup of `pc` that returns `if_instr`.

Top module: `branch_fetch_ctl`

## Requirements
- R1: While reset is held, `pc` equals RESET_PC (default 0), all four stage words equal the nop word 8'h0A, both flags are 0, and `fetch_hold`, `br_resolve` and `br_taken` are 0.
- R2: With no branch present, each clock moves `if_instr` into ID and moves ID to RF, RF to EX and EX to WB, and `pc` advances by one.
- R3: When ID holds a branch, `fetch_hold` is 1. At the next edge the branch moves to RF, ID is loaded with 8'h0A and not the fetched word, and `pc` keeps its value.
- R4: While the branch travels from RF to EX, `pc` stays frozen at the address after the branch, ID stays 8'h0A, and RF receives 8'h0A.
- R5: In the cycle the branch is in EX, `br_resolve` is 1. At the following edge `pc` becomes `ex_target` if the branch is taken, and otherwise stays at the address after the branch.
- R6: A branch is a word whose low four bits are 4'b1101 (always taken), 4'b0101 (taken when Z is 1) or 4'b1001 (taken when N is 1). `br_taken` is 1 only together with `br_resolve`.
- R7: The flags load `ex_alu_n`/`ex_alu_z` only when `ex_alu_en` is 1 and the EX word is neither 8'h0A nor a branch. In every other case they keep their value.
- R8: One cycle after resolution, `fetch_hold` is 0. At the next edge ID loads the word at the new `pc`, and `pc` advances by one from there.
- R9: The program counter increments modulo 2^PC_W (8 bits by default), so 8'hFF is followed by 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_instr | input | IW | Word read from instruction memory at `pc` |
| ex_alu_en | input | 1 | EX datapath ran an ALU operation this cycle |
| ex_alu_n | input | 1 | Negative result from the EX ALU |
| ex_alu_z | input | 1 | Zero result from the EX ALU |
| ex_target | input | PC_W | Branch target computed in EX |
| pc | output | PC_W | Program counter, address for fetch |
| id_ir | output | IW | Word held in ID |
| rf_ir | output | IW | Word held in RF |
| ex_ir | output | IW | Word held in EX |
| wb_ir | output | IW | Word held in WB |
| flag_n | output | 1 | Stored negative flag |
| flag_z | output | 1 | Stored zero flag |
| fetch_hold | output | 1 | Program counter is not advancing this cycle |
| br_resolve | output | 1 | Branch in EX is being resolved this cycle |
| br_taken | output | 1 | The resolving branch is taken |

## Verification
The bench takes each branch kind through every flag combination and checks the program counter one edge after resolution. A controller that used the wrong flag, or read the flags before the preceding ALU result landed, would send fetch to the wrong address. The squash of the word fetched behind the branch and the frozen counter during the pending window are checked cycle by cycle; a controller that leaked the fetched word would execute an instruction from the wrong path. Flag retention is exercised by raising the ALU enable while EX holds a branch and then bubbles, which catches flags clobbered by non-ALU words. Counter wrap at the top of the address space is also covered.

// File: rtl/bctl_pkg.sv
package bctl_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_PEND    = 2'd1,
      ST_RESOLVE = 2'd2
   } bctl_state_t;

   typedef enum logic [1:0] {
      BK_NONE   = 2'd0,
      BK_ALWAYS = 2'd1,
      BK_ZERO   = 2'd2,
      BK_NEG    = 2'd3
   } br_kind_t;

endpackage

// File: rtl/bctl_decode.sv
module bctl_decode
   import bctl_pkg::*;
#(
   parameter int unsigned IW    = 8,
   parameter int unsigned OPC_W = 4,
   parameter logic [OPC_W-1:0] OP_BR = 4'hD,
   parameter logic [OPC_W-1:0] OP_BZ = 4'h5,
   parameter logic [OPC_W-1:0] OP_BN = 4'h9
) (
   input  logic [IW-1:0] word_i,
   output br_kind_t      kind_o,
   output logic          is_br_o
);
   logic [OPC_W-1:0] opc;
   assign opc = word_i[OPC_W-1:0];

   always_comb begin
      if (opc == OP_BR)      kind_o = BK_ALWAYS;
      else if (opc == OP_BZ) kind_o = BK_ZERO;
      else if (opc == OP_BN) kind_o = BK_NEG;
      else                   kind_o = BK_NONE;
   end

   assign is_br_o = (kind_o != BK_NONE);
endmodule

// File: rtl/bctl_pc.sv
module bctl_pc #(
   parameter int unsigned      PC_W     = 8,
   parameter logic [PC_W-1:0]  RESET_PC = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            advance_i,
   input  logic            load_i,
   input  logic [PC_W-1:0] load_val_i,
   output logic [PC_W-1:0] pc_o
);
   logic [PC_W-1:0] pc_q;
   logic [PC_W-1:0] pc_inc;

   // dedicated incrementer, independent of the EX ALU
   assign pc_inc = pc_q + PC_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)         pc_q <= RESET_PC;
      else if (load_i)    pc_q <= load_val_i;
      else if (advance_i) pc_q <= pc_inc;
   end

   assign pc_o = pc_q;
endmodule

// File: rtl/bctl_flags.sv
module bctl_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic we_i,
   input  logic n_i,
   input  logic z_i,
   output logic n_o,
   output logic z_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         n_o <= 1'b0;
         z_o <= 1'b0;
      end else if (we_i) begin
         n_o <= n_i;
         z_o <= z_i;
      end
   end
endmodule

// File: rtl/bctl_irpipe.sv
module bctl_irpipe #(
   parameter int unsigned    IW       = 8,
   parameter int unsigned    DEPTH    = 3,
   parameter logic [IW-1:0]  NOP_WORD = 8'h0A
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [IW-1:0]         fetch_i,
   input  logic                  squash_i,
   output logic [DEPTH:0][IW-1:0] stg_o
);
   // stage 0 is ID; it takes the fetched word or a bubble
   always_ff @(posedge clk) begin
      if (!rst_n)        stg_o[0] <= NOP_WORD;
      else if (squash_i) stg_o[0] <= NOP_WORD;
      else               stg_o[0] <= fetch_i;
   end

   for (genvar s = 1; s <= DEPTH; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) stg_o[s] <= NOP_WORD;
         else        stg_o[s] <= stg_o[s-1];
      end
   end
endmodule

// File: rtl/bctl_fsm.sv
module bctl_fsm
   import bctl_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        id_is_br_i,
   input  logic        ex_is_br_i,
   output bctl_state_t state_o,
   output logic        hold_o,
   output logic        resolve_o,
   output logic        squash_o
);
   bctl_state_t nxt;

   always_comb begin
      nxt       = state_o;
      hold_o    = 1'b0;
      resolve_o = 1'b0;
      squash_o  = 1'b0;
      unique case (state_o)
         ST_IDLE: begin
            if (id_is_br_i) begin
               hold_o   = 1'b1;
               squash_o = 1'b1;
               nxt      = ST_PEND;
            end
         end
         ST_PEND: begin
            hold_o   = 1'b1;
            squash_o = 1'b1;
            if (ex_is_br_i) begin
               resolve_o = 1'b1;
               nxt       = ST_RESOLVE;
            end
         end
         ST_RESOLVE: nxt = ST_IDLE;
         default:    nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_o <= ST_IDLE;
      else        state_o <= nxt;
   end
endmodule

// File: rtl/branch_fetch_ctl.sv
module branch_fetch_ctl
   import bctl_pkg::*;
#(
   parameter int unsigned      PC_W     = 8,
   parameter int unsigned      IW       = 8,
   parameter int unsigned      OPC_W    = 4,
   parameter logic [PC_W-1:0]  RESET_PC = '0,
   parameter logic [IW-1:0]    NOP_WORD = 8'h0A,
   parameter logic [OPC_W-1:0] OP_BR    = 4'hD,
   parameter logic [OPC_W-1:0] OP_BZ    = 4'h5,
   parameter logic [OPC_W-1:0] OP_BN    = 4'h9
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [IW-1:0]   if_instr,
   input  logic            ex_alu_en,
   input  logic            ex_alu_n,
   input  logic            ex_alu_z,
   input  logic [PC_W-1:0] ex_target,
   output logic [PC_W-1:0] pc,
   output logic [IW-1:0]   id_ir,
   output logic [IW-1:0]   rf_ir,
   output logic [IW-1:0]   ex_ir,
   output logic [IW-1:0]   wb_ir,
   output logic            flag_n,
   output logic            flag_z,
   output logic            fetch_hold,
   output logic            br_resolve,
   output logic            br_taken
);
   localparam int unsigned LATE_STAGES = 3;   // RF, EX, WB
   localparam int unsigned ST_ID = 0;
   localparam int unsigned ST_RF = 1;
   localparam int unsigned ST_EX = 2;
   localparam int unsigned ST_WB = 3;

   initial begin
      if (OPC_W == 0 || OPC_W > IW)
         $error("branch_fetch_ctl: OPC_W must be in 1..IW");
      if (OP_BR == OP_BZ || OP_BR == OP_BN || OP_BZ == OP_BN)
         $error("branch_fetch_ctl: branch opcodes must differ");
      if (NOP_WORD[OPC_W-1:0] == OP_BR || NOP_WORD[OPC_W-1:0] == OP_BZ ||
          NOP_WORD[OPC_W-1:0] == OP_BN)
         $error("branch_fetch_ctl: nop word decodes as a branch");
   end

   logic [LATE_STAGES:0][IW-1:0] stg;
   br_kind_t    id_kind, ex_kind;
   logic        id_is_br, ex_is_br;
   bctl_state_t state;
   logic        squash, cond_met, flag_we, advance;

   bctl_decode #(.IW(IW), .OPC_W(OPC_W), .OP_BR(OP_BR), .OP_BZ(OP_BZ), .OP_BN(OP_BN))
      i_dec_id (.word_i(stg[ST_ID]), .kind_o(id_kind), .is_br_o(id_is_br));

   bctl_decode #(.IW(IW), .OPC_W(OPC_W), .OP_BR(OP_BR), .OP_BZ(OP_BZ), .OP_BN(OP_BN))
      i_dec_ex (.word_i(stg[ST_EX]), .kind_o(ex_kind), .is_br_o(ex_is_br));

   bctl_fsm i_fsm (
      .clk(clk), .rst_n(rst_n),
      .id_is_br_i(id_is_br), .ex_is_br_i(ex_is_br),
      .state_o(state), .hold_o(fetch_hold),
      .resolve_o(br_resolve), .squash_o(squash)
   );

   bctl_irpipe #(.IW(IW), .DEPTH(LATE_STAGES), .NOP_WORD(NOP_WORD)) i_pipe (
      .clk(clk), .rst_n(rst_n), .fetch_i(if_instr),
      .squash_i(squash), .stg_o(stg)
   );

   // a stage word that is a bubble or a branch never touches the flags
   assign flag_we = ex_alu_en && (stg[ST_EX] != NOP_WORD) && !ex_is_br;

   bctl_flags i_flags (
      .clk(clk), .rst_n(rst_n), .we_i(flag_we),
      .n_i(ex_alu_n), .z_i(ex_alu_z), .n_o(flag_n), .z_o(flag_z)
   );

   always_comb begin
      unique case (ex_kind)
         BK_ALWAYS: cond_met = 1'b1;
         BK_ZERO:   cond_met = flag_z;
         BK_NEG:    cond_met = flag_n;
         default:   cond_met = 1'b0;
      endcase
   end

   assign br_taken = br_resolve && cond_met;
   assign advance  = !fetch_hold && (state != ST_PEND);

   bctl_pc #(.PC_W(PC_W), .RESET_PC(RESET_PC)) i_pc (
      .clk(clk), .rst_n(rst_n), .advance_i(advance),
      .load_i(br_taken), .load_val_i(ex_target), .pc_o(pc)
   );

   assign id_ir = stg[ST_ID];
   assign rf_ir = stg[ST_RF];
   assign ex_ir = stg[ST_EX];
   assign wb_ir = stg[ST_WB];
endmodule

// File: rtl/bctl_checker.sv
module bctl_checker #(
   parameter int unsigned      PC_W     = 8,
   parameter int unsigned      IW       = 8,
   parameter int unsigned      OPC_W    = 4,
   parameter logic [IW-1:0]    NOP_WORD = 8'h0A,
   parameter logic [OPC_W-1:0] OP_BR    = 4'hD
) (
   input logic            clk,
   input logic            rst_n,
   input logic [PC_W-1:0] pc,
   input logic [IW-1:0]   id_ir,
   input logic [IW-1:0]   rf_ir,
   input logic [IW-1:0]   ex_ir,
   input logic [IW-1:0]   wb_ir,
   input logic            flag_n,
   input logic            flag_z,
   input logic            ex_alu_en,
   input logic            fetch_hold,
   input logic            br_resolve,
   input logic            br_taken
);
   assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!fetch_hold && !br_resolve) |=> pc == PC_W'($past(pc) + PC_W'(1)));

   assert_shift_ex_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (ex_ir == $past(rf_ir)) && (wb_ir == $past(ex_ir)));

   assert_squash_id_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_hold && !br_resolve) |=> id_ir == NOP_WORD);

   assert_pc_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_hold && !br_resolve) |=> $stable(pc));

   assert_taken_in_resolve_R6: assert property (@(posedge clk) disable iff (!rst_n)
      br_taken |-> br_resolve);

   assert_always_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (br_resolve && ex_ir[OPC_W-1:0] == OP_BR) |-> br_taken);

   assert_resume_R8: assert property (@(posedge clk) disable iff (!rst_n)
      br_resolve |=> !fetch_hold);

   assert_flags_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !ex_alu_en |=> $stable({flag_n, flag_z}));
endmodule

bind branch_fetch_ctl bctl_checker #(
   .PC_W(PC_W), .IW(IW), .OPC_W(OPC_W), .NOP_WORD(NOP_WORD), .OP_BR(OP_BR)
) i_bctl_checker (
   .clk(clk), .rst_n(rst_n), .pc(pc), .id_ir(id_ir), .rf_ir(rf_ir),
   .ex_ir(ex_ir), .wb_ir(wb_ir), .flag_n(flag_n), .flag_z(flag_z),
   .ex_alu_en(ex_alu_en), .fetch_hold(fetch_hold),
   .br_resolve(br_resolve), .br_taken(br_taken)
);

// File: tb/test_branch_fetch_ctl.sv
`timescale 1ns/1ps
module test_branch_fetch_ctl;
   localparam logic [7:0] NOPW   = 8'h0A;
   localparam logic [7:0] ALUW   = 8'h0B;
   localparam logic [7:0] TARGET = 8'h40;
   localparam logic [7:0] TWORD  = 8'h33;
   localparam int NVEC = 10;
   // {branch word, n, z, expected taken}
   localparam logic [10:0] VEC [NVEC] = '{
      {8'h0D,1'b0,1'b0,1'b1}, {8'h0D,1'b1,1'b1,1'b1},
      {8'h05,1'b0,1'b0,1'b0}, {8'h05,1'b0,1'b1,1'b1},
      {8'h05,1'b1,1'b0,1'b0}, {8'h05,1'b1,1'b1,1'b1},
      {8'h09,1'b0,1'b0,1'b0}, {8'h09,1'b1,1'b0,1'b1},
      {8'h09,1'b0,1'b1,1'b0}, {8'h09,1'b1,1'b1,1'b1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [7:0] mem [256];
   logic [7:0] if_instr, pc, id_ir, rf_ir, ex_ir, wb_ir;
   logic alu_force = 1'b0, drv_n = 1'b0, drv_z = 1'b0;
   logic ex_alu_en, flag_n, flag_z, fetch_hold, br_resolve, br_taken;
   int checks = 0, errors = 0;

   always #2 clk = ~clk;

   assign if_instr  = mem[pc];
   assign ex_alu_en = alu_force || (ex_ir == ALUW);

   branch_fetch_ctl i_branch_fetch_ctl (
      .clk(clk), .rst_n(rst_n), .if_instr(if_instr), .ex_alu_en(ex_alu_en),
      .ex_alu_n(drv_n), .ex_alu_z(drv_z), .ex_target(TARGET),
      .pc(pc), .id_ir(id_ir), .rf_ir(rf_ir), .ex_ir(ex_ir), .wb_ir(wb_ir),
      .flag_n(flag_n), .flag_z(flag_z), .fetch_hold(fetch_hold),
      .br_resolve(br_resolve), .br_taken(br_taken)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic fill_mem();
      for (int i = 0; i < 256; i++) mem[i] = {i[3:0], 4'h0};
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      tick();
      tick();
      rst_n = 1'b1;
   endtask

   initial begin
      #(200000 * 4);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      fill_mem();
      @(negedge clk);
      rst_n = 1'b0;
      tick();
      tick();
      // R1 reset state
      chk("R1 pc", pc, 0);
      chk("R1 stages", {id_ir, rf_ir, ex_ir, wb_ir}, {4{NOPW}});
      chk("R1 flags", {flag_n, flag_z}, 0);
      chk("R1 ctl", {fetch_hold, br_resolve, br_taken}, 0);
      rst_n = 1'b1;

      // R2 straight-line flow
      for (int k = 0; k < 4; k++) tick();
      chk("R2 pc", pc, 4);
      chk("R2 stages", {id_ir, rf_ir, ex_ir, wb_ir}, {mem[3], mem[2], mem[1], mem[0]});
      chk("R2 no hold", fetch_hold, 0);

      // table of branch cases (R3..R6, R8)
      for (int v = 0; v < NVEC; v++) begin
         logic [7:0] bw;
         logic exp_t;
         logic [7:0] exp_pc;
         bw = VEC[v][10:3];
         exp_t = VEC[v][0];
         exp_pc = exp_t ? TARGET : 8'h02;
         fill_mem();
         mem[0] = ALUW;
         mem[1] = bw;
         mem[TARGET] = TWORD;
         drv_n = VEC[v][2];
         drv_z = VEC[v][1];
         do_reset();
         tick();
         tick();                                   // branch in ID
         chk("R3 hold with branch in ID", fetch_hold, 1);
         tick();                                   // branch in RF
         chk("R3 pc kept", pc, 2);
         chk("R3 fetched word dropped", id_ir, NOPW);
         chk("R3 branch in RF", rf_ir, bw);
         tick();                                   // branch in EX
         chk("R4 pc frozen", pc, 2);
         chk("R4 bubble into RF", rf_ir, NOPW);
         chk("R4 id bubble", id_ir, NOPW);
         chk("R5 resolve", br_resolve, 1);
         chk("R6 taken", br_taken, exp_t);
         tick();
         chk("R5 pc after resolve", pc, exp_pc);
         chk("R8 hold released", fetch_hold, 0);
         tick();
         chk("R8 refetch", id_ir, mem[exp_pc]);
         chk("R8 pc advanced", pc, 8'(exp_pc + 1));
      end

      // R7 flags keep value while EX holds a branch or a bubble
      fill_mem();
      mem[0] = ALUW;
      mem[1] = 8'h05;
      drv_n = 1'b1;
      drv_z = 1'b1;
      do_reset();
      for (int k = 0; k < 4; k++) tick();       // flags loaded, branch in EX
      chk("R7 flags loaded", {flag_n, flag_z}, 2'b11);
      alu_force = 1'b1;
      drv_n = 1'b0;
      drv_z = 1'b0;
      tick();                                   // EX held a branch
      chk("R7 branch keeps flags", {flag_n, flag_z}, 2'b11);
      tick();                                   // EX held a bubble
      chk("R7 bubble keeps flags", {flag_n, flag_z}, 2'b11);
      alu_force = 1'b0;
      for (int k = 0; k < 4; k++) tick();
      chk("R7 no enable keeps flags", {flag_n, flag_z}, 2'b11);

      // R9 counter wrap
      fill_mem();
      do_reset();
      for (int k = 0; k < 255; k++) tick();
      chk("R9 pc top", pc, 8'hFF);
      tick();
      chk("R9 pc wrap", pc, 8'h00);
      chk("R9 id after wrap", id_ir, mem[255]);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule